// File: doc/BRIEF.md
# Staged configuration commit controller

This block is a register file on a 32-bit register bus with word stride. It holds configuration words for a frequency-ramp engine in two copies. Software writes the staging copy freely. The downstream engine reads only the active copy, which changes only when software commits an entry through a handshake on the update register.

A commit has three steps. Software first writes an entry ID into the update register with the enable bit clear. It then writes the same ID with the enable bit set. A fixed number of cycles later, one acknowledge bit rises in the upper half of the update register. That acknowledge stays set until software writes the update register with the enable bit clear, which clears the whole acknowledge field.

Each entry ID selects one staged word. A group of several words uses one ID per word, counting down from the group's base ID. A separate command register holds a root-enable control and a short busy indication that appears after root enable is set.

Top module: `cfg_commit_ctrl`

## Requirements
- R1: After reset, every staging word, every active output, the root-enable bit, the busy bit and the whole update register (ID, enable bit and acknowledge field) read 0.
- R2: Staging words are read/write at these byte addresses: scale words 0..7 at 0x10 + 4·i, limit words 0..2 at 0x30 + 4·i, the link word at 0x40 and the ramp word at 0x50. A read of any address that decodes to nothing (for example 0x04 or 0x44) returns 0, and a write there changes no register.
- R3: The command register is at address 0x00. Bit 1 is root enable and is read/write. Bit 0 is busy and is read-only. A write with bit 1 set makes busy read 1 in the two cycles after the write and 0 from then on. A write with bit 1 clear clears both bits.
- R4: The update register is at address 0x60. Bits 7:0 hold the entry ID and bit 8 is the enable bit; both read back as last written. Bits 31:16 are the read-only acknowledge field.
- R5: A write to the update register is accepted as a commit when bit 8 is set, the ID is at most 15, the acknowledge field is zero and no commit is in flight. The acknowledge bit at position 16 + ID then rises exactly 4 cycles after the write. The acknowledge field never has more than one bit set.
- R6: On completion, a commit copies one staged word to its active output. IDs 14 down to 7 select scale words 0 to 7. IDs 6, 5 and 4 select limit words 0, 1 and 2. ID 3 selects the link word and ID 2 selects the ramp word. IDs 0, 1 and 15 are acknowledged but copy nothing.
- R7: An active output changes only when a commit of its own ID completes. Writes to staging words alone leave all active outputs unchanged.
- R8: The acknowledge field holds its value until software writes the update register with bit 8 clear. The field then reads 0 in the following cycle.
- R9: A commit request is ignored and raises no acknowledge and no copy in three cases: the ID is above 15, the acknowledge field is nonzero, or another commit is still in flight.
- R10: The ramp enable sequence 0x800, 0xC00, 0x400 and the disable value 0x0 are each staged at 0x50 and committed under ID 2. After each commit the ramp output carries that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe; a write takes effect on the clock edge |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 7 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| act_scale_o | output | 256 | Active scale words, word i in bits 32·i+31:32·i |
| act_limit_o | output | 96 | Active limit words, word i in bits 32·i+31:32·i |
| act_link_o | output | 32 | Active link word |
| act_ramp_o | output | 32 | Active ramp control word |

## Verification
A wrong commit counter shows up as an acknowledge bit that rises a cycle early or late. It can also show up as a hang with no acknowledge at all, which the bench's cycle-exact poll catches within five cycles of the enable write. A wrong ID-to-word map, or a copy taken at the wrong moment, leaves an active output that differs from the staged word. This is visible on the output pins as soon as the acknowledge appears. A clear or guard condition that is lost is visible on the next handshake step: the field stays nonzero after the zero write, or an acknowledge appears for a request that must be ignored.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
   localparam int DW      = 32;
   localparam int AW      = 7;
   localparam int IDW     = 8;
   localparam int ID_MAX  = 15;
   localparam int ACKW    = ID_MAX + 1;
   localparam int EN_BIT  = 8;

   localparam logic [AW-1:0] A_CMD   = 7'h00;
   localparam logic [AW-1:0] A_SCALE = 7'h10;
   localparam logic [AW-1:0] A_LIMIT = 7'h30;
   localparam logic [AW-1:0] A_LINK  = 7'h40;
   localparam logic [AW-1:0] A_RAMP  = 7'h50;
   localparam logic [AW-1:0] A_UPD   = 7'h60;

   localparam int ID_RAMP  = 2;
   localparam int ID_LINK  = 3;
   localparam int ID_LIMIT = 6;
   localparam int ID_SCALE = 14;

   // word k of the flat staging table: scale words, limit words, link, ramp
   function automatic int word_addr(int k, int sn, int ln);
      if (k < sn)           return int'(A_SCALE) + 4 * k;
      else if (k < sn + ln) return int'(A_LIMIT) + 4 * (k - sn);
      else if (k == sn + ln) return int'(A_LINK);
      else                  return int'(A_RAMP);
   endfunction

   function automatic int word_id(int k, int sn, int ln);
      if (k < sn)           return ID_SCALE - k;
      else if (k < sn + ln) return ID_LIMIT - (k - sn);
      else if (k == sn + ln) return ID_LINK;
      else                  return ID_RAMP;
   endfunction
endpackage

// File: rtl/cfgc_regs.sv
module cfgc_regs
   import cfgc_pkg::*;
#(
   parameter int SCALE_N  = 8,
   parameter int LIMIT_N  = 3,
   parameter int BUSY_CYC = 2,
   localparam int NW      = SCALE_N + LIMIT_N + 2,
   localparam int BCW     = $clog2(BUSY_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [ACKW-1:0]  ack_i,
   input  logic [IDW-1:0]   upd_id_i,
   input  logic             upd_en_i,
   output logic [NW*DW-1:0] stg_o,
   output logic             busy_o,
   output logic [DW-1:0]    rdata_o
);
   logic [NW-1:0]  hit;
   logic           root_q;
   logic [BCW-1:0] bcnt_q;

   for (genvar k = 0; k < NW; k++) begin : g_word
      localparam logic [AW-1:0] WA = AW'(word_addr(k, SCALE_N, LIMIT_N));
      logic [DW-1:0] word_q;
      assign hit[k] = (addr_i == WA);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              word_q <= '0;
         else if (wr_i && hit[k]) word_q <= wdata_i;
      end
      assign stg_o[k*DW +: DW] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q <= 1'b0;
         bcnt_q <= '0;
      end else if (wr_i && addr_i == A_CMD) begin
         root_q <= wdata_i[1];
         bcnt_q <= wdata_i[1] ? BCW'(BUSY_CYC) : '0;
      end else if (bcnt_q != '0) begin
         bcnt_q <= bcnt_q - 1'b1;
      end
   end

   assign busy_o = (bcnt_q != '0);

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_CMD)
         rdata_o = {{(DW-2){1'b0}}, root_q, busy_o};
      else if (addr_i == A_UPD)
         rdata_o = {ack_i, {(DW-ACKW-IDW-1){1'b0}}, upd_en_i, upd_id_i};
      for (int k = 0; k < NW; k++)
         if (hit[k]) rdata_o = stg_o[k*DW +: DW];
   end
endmodule

// File: rtl/cfgc_commit.sv
module cfgc_commit
   import cfgc_pkg::*;
#(
   parameter int COMMIT_LAT = 4,
   localparam int LCW       = $clog2(COMMIT_LAT + 1),
   localparam int TW        = $clog2(ACKW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_wr_i,
   input  logic [IDW:0]    wdata_i,
   output logic [IDW-1:0]  id_o,
   output logic            en_o,
   output logic [ACKW-1:0] ack_o,
   output logic            accept_o,
   output logic            fire_o,
   output logic [TW-1:0]   fire_id_o
);
   logic [LCW-1:0] lcnt_q;

   assign accept_o = upd_wr_i && wdata_i[EN_BIT] && (ack_o == '0) &&
                     (lcnt_q == '0) && (wdata_i[IDW-1:0] <= IDW'(ID_MAX));
   assign fire_o   = (lcnt_q == LCW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_o      <= '0;
         en_o      <= 1'b0;
         lcnt_q    <= '0;
         fire_id_o <= '0;
      end else begin
         if (upd_wr_i) begin
            id_o <= wdata_i[IDW-1:0];
            en_o <= wdata_i[EN_BIT];
         end
         if (accept_o) begin
            lcnt_q    <= LCW'(COMMIT_LAT);
            fire_id_o <= wdata_i[TW-1:0];
         end else if (lcnt_q != '0) begin
            lcnt_q <= lcnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ack_o <= '0;
      else if (fire_o)                      ack_o <= ACKW'(1) << fire_id_o;
      else if (upd_wr_i && !wdata_i[EN_BIT]) ack_o <= '0;
   end
endmodule

// File: rtl/cfgc_active.sv
module cfgc_active
   import cfgc_pkg::*;
#(
   parameter int SCALE_N  = 8,
   parameter int LIMIT_N  = 3,
   localparam int NW      = SCALE_N + LIMIT_N + 2,
   localparam int TW      = $clog2(ACKW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [TW-1:0]    fire_id_i,
   input  logic [NW*DW-1:0] stg_i,
   output logic [NW*DW-1:0] act_o
);
   for (genvar k = 0; k < NW; k++) begin : g_act
      localparam logic [TW-1:0] WID = TW'(word_id(k, SCALE_N, LIMIT_N));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_o[k*DW +: DW] <= '0;
         else if (fire_i && fire_id_i == WID)
            act_o[k*DW +: DW] <= stg_i[k*DW +: DW];
      end
   end
endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
   import cfgc_pkg::*;
#(
   parameter int SCALE_N    = 8,
   parameter int LIMIT_N    = 3,
   parameter int COMMIT_LAT = 4,
   parameter int BUSY_CYC   = 2,
   localparam int NW        = SCALE_N + LIMIT_N + 2,
   localparam int TW        = $clog2(ACKW)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid_i,
   input  logic                  bus_write_i,
   input  logic [AW-1:0]         bus_addr_i,
   input  logic [DW-1:0]         bus_wdata_i,
   output logic [DW-1:0]         bus_rdata_o,
   output logic [SCALE_N*DW-1:0] act_scale_o,
   output logic [LIMIT_N*DW-1:0] act_limit_o,
   output logic [DW-1:0]         act_link_o,
   output logic [DW-1:0]         act_ramp_o
);
   if (SCALE_N < 1 || SCALE_N > 8) begin : g_bad_scale
      $error("SCALE_N must fit IDs 14 down to 7 and the window at 0x10");
   end
   if (LIMIT_N < 1 || LIMIT_N > 3) begin : g_bad_limit
      $error("LIMIT_N must fit IDs 6 down to 4");
   end
   if (COMMIT_LAT < 1) begin : g_bad_lat
      $error("COMMIT_LAT must be at least 1");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end

   logic             wr;
   logic             cmd_busy;
   logic [ACKW-1:0]  upd_ack;
   logic [IDW-1:0]   upd_id;
   logic             upd_en;
   logic             commit_accept;
   logic             commit_fire;
   logic [TW-1:0]    commit_id;
   logic [NW*DW-1:0] stg_all;
   logic [NW*DW-1:0] act_all;

   assign wr = bus_valid_i && bus_write_i;

   cfgc_regs #(.SCALE_N(SCALE_N), .LIMIT_N(LIMIT_N), .BUSY_CYC(BUSY_CYC)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .ack_i(upd_ack), .upd_id_i(upd_id),
      .upd_en_i(upd_en), .stg_o(stg_all), .busy_o(cmd_busy),
      .rdata_o(bus_rdata_o)
   );

   cfgc_commit #(.COMMIT_LAT(COMMIT_LAT)) u_commit (
      .clk(clk), .rst_n(rst_n), .upd_wr_i(wr && bus_addr_i == A_UPD),
      .wdata_i(bus_wdata_i[IDW:0]), .id_o(upd_id), .en_o(upd_en),
      .ack_o(upd_ack), .accept_o(commit_accept), .fire_o(commit_fire),
      .fire_id_o(commit_id)
   );

   cfgc_active #(.SCALE_N(SCALE_N), .LIMIT_N(LIMIT_N)) u_active (
      .clk(clk), .rst_n(rst_n), .fire_i(commit_fire), .fire_id_i(commit_id),
      .stg_i(stg_all), .act_o(act_all)
   );

   assign act_scale_o = act_all[SCALE_N*DW-1:0];
   assign act_limit_o = act_all[(SCALE_N+LIMIT_N)*DW-1 : SCALE_N*DW];
   assign act_link_o  = act_all[(SCALE_N+LIMIT_N+1)*DW-1 : (SCALE_N+LIMIT_N)*DW];
   assign act_ramp_o  = act_all[NW*DW-1 : (SCALE_N+LIMIT_N+1)*DW];
endmodule

// File: rtl/cfg_commit_ctrl_chk.sv
module cfg_commit_ctrl_chk
   import cfgc_pkg::*;
#(
   parameter int COMMIT_LAT = 4,
   parameter int NWB        = 13 * 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr,
   input logic [AW-1:0]   addr,
   input logic [IDW:0]    wd,
   input logic [ACKW-1:0] ack,
   input logic            accept,
   input logic            fire,
   input logic            busy,
   input logic [NWB-1:0]  act
);
   logic upd_wr, cmd_wr;
   int   lat_cnt;

   assign upd_wr = wr && addr == A_UPD;
   assign cmd_wr = wr && addr == A_CMD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lat_cnt <= 0;
      else if (accept)            lat_cnt <= 1;
      else if (fire)              lat_cnt <= 0;
      else if (lat_cnt != 0)      lat_cnt <= lat_cnt + 1;
   end

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack)); // R5
   AST_FIRE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> lat_cnt == COMMIT_LAT); // R5
   AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ack != '0); // R5
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_wr && !wd[EN_BIT] && !fire) |=> ack == '0); // R8
   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack != '0 && !upd_wr) |=> $stable(ack)); // R8
   AST_NO_ACCEPT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      ack != '0 |-> !accept); // R9
   AST_NO_ACCEPT_BADID: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_wr && wd[IDW-1:0] > IDW'(ID_MAX)) |-> !accept); // R9
   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(act)); // R7
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wd[1]) |=> busy); // R3
endmodule

bind cfg_commit_ctrl cfg_commit_ctrl_chk #(.COMMIT_LAT(COMMIT_LAT), .NWB(NW*DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr_i),
   .wd(bus_wdata_i[8:0]), .ack(upd_ack), .accept(commit_accept),
   .fire(commit_fire), .busy(cmd_busy), .act(act_all)
);

// File: tb/cfg_commit_ctrl_bench.sv
module cfg_commit_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 13;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_valid_i = 1'b0;
   logic         bus_write_i = 1'b0;
   logic [6:0]   bus_addr_i = '0;
   logic [31:0]  bus_wdata_i = '0;
   logic [31:0]  bus_rdata_o;
   logic [255:0] act_scale_o;
   logic [95:0]  act_limit_o;
   logic [31:0]  act_link_o;
   logic [31:0]  act_ramp_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [31:0] stg_m [NW];
   logic [31:0] act_m [NW];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_commit_ctrl u_cfg_commit_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid_i),
      .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .act_scale_o(act_scale_o), .act_limit_o(act_limit_o),
      .act_link_o(act_link_o), .act_ramp_o(act_ramp_o)
   );

   function automatic logic [6:0] addr_of(int k);
      if (k < 8)       return 7'(8'h10 + 4 * k);
      else if (k < 11) return 7'(8'h30 + 4 * (k - 8));
      else if (k == 11) return 7'h40;
      else             return 7'h50;
   endfunction

   function automatic int word_of_id(int id);
      if (id >= 7 && id <= 14) return 14 - id;
      if (id >= 4 && id <= 6)  return 8 + (6 - id);
      if (id == 3)             return 11;
      if (id == 2)             return 12;
      return -1;
   endfunction

   function automatic logic [31:0] act_word(int k);
      if (k < 8)        return act_scale_o[k*32 +: 32];
      else if (k < 11)  return act_limit_o[(k-8)*32 +: 32];
      else if (k == 11) return act_link_o;
      else              return act_ramp_o;
   endfunction

   task automatic chk(string req, logic [31:0] a, logic [31:0] e);
      n_tests++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, a, e);
      end
   endtask

   task automatic bus_wr(logic [6:0] a, logic [31:0] d);
      bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_valid_i = 1'b0; bus_write_i = 1'b0;
   endtask

   task automatic bus_rd(logic [6:0] a, output logic [31:0] d);
      bus_addr_i = a;
      #1 d = bus_rdata_o;
   endtask

   task automatic check_active(string req);
      for (int k = 0; k < NW; k++) chk(req, act_word(k), act_m[k]);
   endtask

   task automatic stage(int k, logic [31:0] d);
      bus_wr(addr_of(k), d);
      stg_m[k] = d;
   endtask

   // full handshake with cycle-exact acknowledge timing
   task automatic do_commit(int id, string req);
      logic [31:0] r;
      int k;
      bus_wr(7'h60, 32'(id));
      bus_wr(7'h60, 32'h100 | 32'(id));
      bus_rd(7'h60, r); chk("R5 ack early", 32'(r[31:16]), 0);
      for (int t = 0; t < 3; t++) begin
         @(negedge clk); bus_rd(7'h60, r);
         chk("R5 ack early", 32'(r[31:16]), 0);
      end
      @(negedge clk); bus_rd(7'h60, r);
      chk("R5 ack bit", 32'(r[31:16]), 32'(16'(1) << id));
      k = word_of_id(id);
      if (k >= 0) act_m[k] = stg_m[k];
      check_active(req);
      bus_wr(7'h60, 32'h0);
      bus_rd(7'h60, r); chk("R8 ack cleared", r, 32'h0);
   endtask

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20240607));
      for (int k = 0; k < NW; k++) begin stg_m[k] = '0; act_m[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd(7'h00, r); chk("R1 cmd", r, 0);
      bus_rd(7'h60, r); chk("R1 update", r, 0);
      for (int k = 0; k < NW; k++) begin bus_rd(addr_of(k), r); chk("R1 staging", r, 0); end
      check_active("R1 active");

      // R2 unmapped addresses
      bus_wr(7'h04, 32'hDEADBEEF);
      bus_wr(7'h44, 32'h12345678);
      bus_rd(7'h04, r); chk("R2 unmapped read", r, 0);
      bus_rd(7'h44, r); chk("R2 unmapped read", r, 0);
      for (int k = 0; k < NW; k++) begin bus_rd(addr_of(k), r); chk("R2 no alias", r, 0); end

      // R3 root enable and busy window
      bus_wr(7'h00, 32'h2);
      bus_rd(7'h00, r); chk("R3 busy cycle 1", r, 32'h3);
      @(negedge clk); bus_rd(7'h00, r); chk("R3 busy cycle 2", r, 32'h3);
      @(negedge clk); bus_rd(7'h00, r); chk("R3 ready", r, 32'h2);
      bus_wr(7'h00, 32'h0);
      bus_rd(7'h00, r); chk("R3 root cleared", r, 32'h0);

      // R4 / R9 out-of-range ID: readback, no acknowledge
      bus_wr(7'h60, 32'h1AB);
      bus_rd(7'h60, r); chk("R4 readback", r, 32'h1AB);
      repeat (6) @(negedge clk);
      bus_rd(7'h60, r); chk("R9 id above 15", r, 32'h1AB);
      bus_wr(7'h60, 32'h0);

      // R7 staging alone never reaches outputs
      for (int k = 0; k < NW; k++) stage(k, $urandom);
      repeat (6) @(negedge clk);
      check_active("R7 staging only");

      // R9 ignored while acknowledge is set
      do_commit(5, "R6 limit word");
      bus_wr(7'h60, 32'h5);
      bus_wr(7'h60, 32'h105);
      repeat (5) @(negedge clk);
      bus_rd(7'h60, r); chk("R8 ack pending", 32'(r[31:16]), 32'h0020);
      bus_wr(7'h60, 32'h103);
      repeat (6) @(negedge clk);
      bus_rd(7'h60, r); chk("R9 while acked", 32'(r[31:16]), 32'h0020);
      check_active("R9 no copy while acked");
      bus_wr(7'h60, 32'h0);
      bus_rd(7'h60, r); chk("R8 ack cleared", r, 0);

      // R9 ignored while a commit is in flight
      bus_wr(7'h60, 32'h10E);
      bus_wr(7'h60, 32'h103);
      repeat (3) @(negedge clk);
      bus_rd(7'h60, r); chk("R9 in flight", 32'(r[31:16]), 32'h4000);
      act_m[0] = stg_m[0];
      repeat (4) @(negedge clk);
      bus_rd(7'h60, r); chk("R9 in flight", 32'(r[31:16]), 32'h4000);
      check_active("R9 no second copy");
      bus_wr(7'h60, 32'h0);

      // R6 unmapped IDs acknowledge without copy
      do_commit(0, "R6 id 0");
      do_commit(1, "R6 id 1");
      do_commit(15, "R6 id 15");

      // R10 ramp enable and disable sequence
      stage(12, 32'h800); do_commit(2, "R10 pre enable");
      chk("R10 ramp", act_ramp_o, 32'h800);
      stage(12, 32'hC00); do_commit(2, "R10 enable");
      chk("R10 ramp", act_ramp_o, 32'hC00);
      stage(12, 32'h400); do_commit(2, "R10 post enable");
      chk("R10 ramp", act_ramp_o, 32'h400);
      stage(12, 32'h0);   do_commit(2, "R10 disable");
      chk("R10 ramp", act_ramp_o, 32'h0);

      // random staging and commits
      for (int it = 0; it < 40; it++) begin
         int nwr = $urandom_range(1, 3);
         for (int j = 0; j < nwr; j++) begin
            int k = $urandom_range(0, NW - 1);
            stage(k, $urandom);
            bus_rd(addr_of(k), r); chk("R2 staging readback", r, stg_m[k]);
         end
         check_active("R7 before commit");
         do_commit($urandom_range(0, 15), "R6 random commit");
      end

      // full group commits, counting down from each base
      for (int k = 0; k < 11; k++) stage(k, $urandom);
      for (int i = 0; i < 3; i++) do_commit(6 - i, "R6 limit group");
      for (int i = 0; i < 8; i++) do_commit(14 - i, "R6 scale group");
      stage(11, 32'hFC987); do_commit(3, "R6 link");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R5 watchdog: actual hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule